// File: doc/BRIEF.md
# Edge-Set Interrupt Flag Register

This block is one 32-bit interrupt flag register inside a clock and supply supervisor. Twelve status lines come from the rest of the supervisor: oscillator ready, loop lock, loop out of bounds, reference clock stopped, brown-out ready, brown-out detect and similar conditions. A flag latches when its status line goes from zero to one. A line that stays high does not set the flag again. Software reads the register to see which events have happened, and writes ones to the bits it wants to acknowledge.

The supervisor supplies two vectors as inputs. The enable vector decides which flags may raise the single interrupt request. The preset vector holds the flag values the register takes while reset is asserted. This models startup conditions, set by configuration, that leave some flags already raised. The register sits at byte offset 0x08 on a simple bus with separate read and write strobes.

Top module: `edge_flag_reg`

## Requirements
- R1: While reset is low, the flags load the preset vector and the interrupt output is 0. A status line that is already high when reset is released does not set its flag.
- R2: A zero-to-one change on status bit i sets flag i. The new value is visible in read bit i from the clock edge at which the change is first sampled.
- R3: A status line that stays high does not set its flag again after software clears that flag.
- R4: A write to offset 0x08 with a one in bit i (i < 12) clears flag i. A zero in bit i leaves flag i unchanged.
- R5: If a rising edge and a clearing write hit the same flag at the same clock edge, the flag ends up set.
- R6: Bits 31:12 always read as zero. Ones written to those bits change nothing.
- R7: The interrupt output is registered. At each clock edge it takes the OR over all bits of (flags AND enable), using the values present just before that edge.
- R8: A read with busRdEn high and busAddr equal to 0x08 returns the flags in bits 11:0 and changes no state. In every other case the read data is 0. A write to any other address is ignored.
- R9: A one-to-zero change on a status line never sets a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| busAddr | input | 8 | Byte address of the access |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busWrData | input | 32 | Write data, a one in a flag bit clears that flag |
| busRdData | output | 32 | Read data, combinational |
| statusIn | input | 12 | Live status lines, already in the clock domain |
| irqEnable | input | 12 | Per-flag interrupt enables |
| presetFlags | input | 12 | Flag values loaded during reset |
| irqOut | output | 1 | Registered interrupt request |

## Verification
The edge detector is exercised with a single rising line, a line held high across a clear, a falling line, several lines rising together, and all twelve lines rising at once. Together these separate edge sensitivity from level sensitivity. The clear path is driven with an all-zero write, a partial mask, a full mask, a mask with ones in the reserved bits, and a clear that lands on the same edge as a rise; this separates write-one-to-clear from plain overwrite and shows the set-over-clear priority. The enable vector is changed against a fixed flag pattern to show the interrupt is masked per bit and lags by one clock. Reset with a nonzero preset while a status line is high shows that the preset is loaded and that no edge appears when reset is released.

// File: rtl/edge_flag_pkg.sv
package edge_flag_pkg;

  // Strobes from the bus decoder to the flag datapath
  typedef struct packed {
    logic wrHit;   // write addressed to this register
    logic rdHit;   // read addressed to this register
  } regStrobe_t;

endpackage

// File: rtl/edge_flag_ctrl.sv
module edge_flag_ctrl
  import edge_flag_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int NUM_FLAGS = 12,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h08
) (
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWrEn,
  input  logic                 busRdEn,
  input  logic [NUM_FLAGS-1:0] flagVec,
  output regStrobe_t           strobe,
  output logic [DATA_W-1:0]    busRdData
);

  localparam int RSV_W = DATA_W - NUM_FLAGS;

  logic addrHit;

  always_comb begin
    addrHit      = (busAddr == REG_OFFSET);
    strobe.wrHit = busWrEn & addrHit;
    strobe.rdHit = busRdEn & addrHit;
  end

  // Reserved bits are tied low; no access returns anything else there
  always_comb begin
    if (strobe.rdHit) begin
      busRdData = {{RSV_W{1'b0}}, flagVec};
    end else begin
      busRdData = '0;
    end
  end

endmodule

// File: rtl/edge_flag_dp.sv
module edge_flag_dp
  import edge_flag_pkg::*;
#(
  parameter int NUM_FLAGS = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  regStrobe_t           strobe,
  input  logic [NUM_FLAGS-1:0] clrData,
  input  logic [NUM_FLAGS-1:0] statusIn,
  input  logic [NUM_FLAGS-1:0] irqEnable,
  input  logic [NUM_FLAGS-1:0] presetFlags,
  output logic [NUM_FLAGS-1:0] flagVec,
  output logic                 irqOut
);

  logic [NUM_FLAGS-1:0] statusPrev;
  logic [NUM_FLAGS-1:0] flagQ;
  logic [NUM_FLAGS-1:0] flagNext;
  logic [NUM_FLAGS-1:0] riseHit;
  logic [NUM_FLAGS-1:0] clrHit;
  logic                 irqQ;

  // Per-flag cell: the set term is ORed in last, so it wins over a clear
  for (genvar i = 0; i < NUM_FLAGS; i++) begin : gFlag
    assign riseHit[i]  = statusIn[i] & ~statusPrev[i];
    assign clrHit[i]   = strobe.wrHit & clrData[i];
    assign flagNext[i] = (flagQ[i] & ~clrHit[i]) | riseHit[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusPrev <= statusIn;      // no edge is seen when reset is released
      flagQ      <= presetFlags;
      irqQ       <= 1'b0;
    end else begin
      statusPrev <= statusIn;
      flagQ      <= flagNext;
      irqQ       <= |(flagQ & irqEnable);
    end
  end

  assign flagVec = flagQ;
  assign irqOut  = irqQ;

endmodule

// File: rtl/edge_flag_reg.sv
module edge_flag_reg
  import edge_flag_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int NUM_FLAGS = 12,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h08
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWrEn,
  input  logic                 busRdEn,
  input  logic [DATA_W-1:0]    busWrData,
  output logic [DATA_W-1:0]    busRdData,
  input  logic [NUM_FLAGS-1:0] statusIn,
  input  logic [NUM_FLAGS-1:0] irqEnable,
  input  logic [NUM_FLAGS-1:0] presetFlags,
  output logic                 irqOut
);

  regStrobe_t           strobe;
  logic [NUM_FLAGS-1:0] flagVec;
  logic                 unusedRsvBits;

  // Written reserved bits go nowhere
  assign unusedRsvBits = ^busWrData[DATA_W-1:NUM_FLAGS];

  edge_flag_ctrl #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .NUM_FLAGS (NUM_FLAGS),
    .REG_OFFSET(REG_OFFSET)
  ) uCtrl (
    .busAddr  (busAddr),
    .busWrEn  (busWrEn),
    .busRdEn  (busRdEn),
    .flagVec  (flagVec),
    .strobe   (strobe),
    .busRdData(busRdData)
  );

  edge_flag_dp #(
    .NUM_FLAGS(NUM_FLAGS)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .clrData    (busWrData[NUM_FLAGS-1:0]),
    .statusIn   (statusIn),
    .irqEnable  (irqEnable),
    .presetFlags(presetFlags),
    .flagVec    (flagVec),
    .irqOut     (irqOut)
  );

endmodule

// File: rtl/edge_flag_chk.sv
module edge_flag_chk #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int NUM_FLAGS = 12,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h08
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [ADDR_W-1:0]    busAddr,
  input logic                 busWrEn,
  input logic                 busRdEn,
  input logic [NUM_FLAGS-1:0] wrLow,
  input logic [DATA_W-1:0]    busRdData,
  input logic [NUM_FLAGS-1:0] statusIn,
  input logic [NUM_FLAGS-1:0] irqEnable,
  input logic [NUM_FLAGS-1:0] flagVec,
  input logic                 irqOut
);

  // R2 R9: a flag that rises must have seen a status rise
  a_r2_set_needs_rise: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |->
      ((flagVec & ~$past(flagVec)) & ~($past(statusIn) & ~$past(statusIn, 2))) == '0);

  // R4 R8: a flag only falls under a one written to this register
  a_r4_clear_needs_write: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |->
      (($past(flagVec) & ~flagVec) &
       ~(($past(busWrEn) && $past(busAddr) == REG_OFFSET) ? $past(wrLow) : '0)) == '0);

  // R7: registered interrupt follows masked flags by one clock
  a_r7_irq_lag: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (irqOut == $past(|(flagVec & irqEnable))));

  // R6: reserved read bits stay low
  a_r6_rsv_zero: assert property (@(posedge clk) disable iff (!rstN)
    busRdData[DATA_W-1:NUM_FLAGS] == '0);

  // R8: read data is zero unless a read hits this register
  a_r8_idle_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    !(busRdEn && busAddr == REG_OFFSET) |-> busRdData == '0);

endmodule

bind edge_flag_reg edge_flag_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .NUM_FLAGS (NUM_FLAGS),
  .REG_OFFSET(REG_OFFSET)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busWrEn  (busWrEn),
  .busRdEn  (busRdEn),
  .wrLow    (busWrData[NUM_FLAGS-1:0]),
  .busRdData(busRdData),
  .statusIn (statusIn),
  .irqEnable(irqEnable),
  .flagVec  (flagVec),
  .irqOut   (irqOut)
);

// File: tb/sim_edge_flag_reg.sv
module sim_edge_flag_reg;

  logic        clk = 1'b0;
  logic        rstN;
  logic [7:0]  busAddr;
  logic        busWrEn;
  logic        busRdEn;
  logic [31:0] busWrData;
  logic [31:0] busRdData;
  logic [11:0] statusIn;
  logic [11:0] irqEnable;
  logic [11:0] presetFlags;
  logic        irqOut;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  edge_flag_reg u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData),
    .statusIn(statusIn), .irqEnable(irqEnable), .presetFlags(presetFlags),
    .irqOut(irqOut)
  );

  typedef struct packed {
    logic [11:0] st;
    logic        wr;
    logic [31:0] wd;
    logic [11:0] en;
    logic [11:0] expF;
    logic        expI;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{12'h001, 1'b0, 32'h0,        12'h000, 12'h001, 1'b0}, // R2 single rise
    '{12'h001, 1'b1, 32'h001,      12'h000, 12'h000, 1'b0}, // R4 clear
    '{12'h001, 1'b0, 32'h0,        12'hFFF, 12'h000, 1'b0}, // R3 held high, no reset
    '{12'h0F0, 1'b0, 32'h0,        12'hFFF, 12'h0F0, 1'b0}, // R9 bit0 falls, R2 four rise
    '{12'h0F0, 1'b0, 32'h0,        12'hFFF, 12'h0F0, 1'b1}, // R7 one clock lag
    '{12'h0F0, 1'b1, 32'h0,        12'hFFF, 12'h0F0, 1'b1}, // R4 zero write
    '{12'h0F0, 1'b1, 32'h030,      12'hF0F, 12'h0C0, 1'b0}, // R4 partial, R7 masked
    '{12'h0F0, 1'b0, 32'h0,        12'h0C0, 12'h0C0, 1'b1}, // R7 enabled bits
    '{12'h8F0, 1'b1, 32'h8C0,      12'h000, 12'h800, 1'b0}, // R5 set beats clear
    '{12'h8F0, 1'b1, 32'hFFFFF800, 12'h800, 12'h000, 1'b1}, // R6 reserved ones
    '{12'h000, 1'b0, 32'h0,        12'h800, 12'h000, 1'b0}, // R9 all fall
    '{12'hFFF, 1'b0, 32'h0,        12'hFFF, 12'hFFF, 1'b0}, // R2 all rise
    '{12'hFFF, 1'b1, 32'hFFF,      12'hFFF, 12'h000, 1'b1}, // R4 full clear
    '{12'hFFF, 1'b0, 32'h0,        12'hFFF, 12'h000, 1'b0}  // R3 stays clear
  };

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #2000000;
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=done");
    finishRun();
  end

  initial begin
    rstN = 1'b0; busAddr = 8'h08; busWrEn = 1'b0; busRdEn = 1'b0;
    busWrData = '0; statusIn = '0; irqEnable = '0; presetFlags = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    busRdEn = 1'b1;
    #1;
    check32("R1 zero preset", busRdData, 32'h0);
    check32("R1 irq reset", {31'b0, irqOut}, 32'h0);

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      statusIn  = VECS[k].st;
      busWrEn   = VECS[k].wr;
      busWrData = VECS[k].wd;
      irqEnable = VECS[k].en;
      @(posedge clk);
      #1;
      busWrEn = 1'b0;
      check32($sformatf("R2/R4/R5/R6 table step %0d flags", k), busRdData, {20'b0, VECS[k].expF});
      check32($sformatf("R7 table step %0d irq", k), {31'b0, irqOut}, {31'b0, VECS[k].expI});
    end

    // R1: preset load, no edge at release while a line is high
    @(negedge clk);
    rstN = 1'b0; presetFlags = 12'h804; statusIn = 12'h001; irqEnable = '0;
    repeat (2) @(negedge clk);
    #1;
    check32("R1 irq low in reset", {31'b0, irqOut}, 32'h0);
    check32("R1 preset during reset", busRdData, 32'h804);
    @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check32("R1 no edge at release", busRdData, 32'h804);

    // R8: other address ignored and reads zero
    busAddr = 8'h0C; busWrData = 32'hFFF; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
    #1;
    check32("R8 foreign read zero", busRdData, 32'h0);
    busAddr = 8'h08;
    #1;
    check32("R8 foreign write ignored", busRdData, 32'h804);
    @(negedge clk);
    check32("R8 read no side effect", busRdData, 32'h804);
    busRdEn = 1'b0;
    #1;
    check32("R8 no strobe reads zero", busRdData, 32'h0);
    busRdEn = 1'b1;

    // R7: enable change lags one clock
    irqEnable = 12'h004;
    #1;
    check32("R7 irq before edge", {31'b0, irqOut}, 32'h0);
    @(posedge clk);
    #1;
    check32("R7 irq after edge", {31'b0, irqOut}, 32'h1);

    finishRun();
  end

endmodule